// File: doc/BRIEF.md
# Vectored Interrupt Manager

This block gathers a set of peripheral interrupt request lines into per-channel pending flags and gates them with per-channel enable bits. It picks the pending, enabled channel with the lowest index and drives one interrupt line to the CPU. It also looks up the handler address for that channel in a small vector RAM. Software loads that RAM at startup over a simple word-addressed register bus.

The CPU can obtain the handler address in either of two ways. In software mode it reads a vector register over the bus. In hardware-vectored mode it raises a request on a dedicated handshake and receives the address on a vector port. The port holds that address until the block acknowledges. The acknowledge also retires the channel's pending flag.

A pending flag is set by a rising edge on its request line. It stays set until software writes 1 to its bit or a hardware acknowledge retires it. While the flag is set, further edges on that line merge into the same event.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A rising edge (low in one cycle, high in the next) on request line i sets pending bit i at that clock edge. A line held high does not set the bit again after it has been cleared; a new low-to-high transition is needed.
- R2: While pending bit i is already set, further rising edges on line i are not counted as new events. A single clear of bit i returns it to 0.
- R3: Writing to the pending register (address 0) clears each pending bit whose write-data bit is 1 and leaves bits written 0 unchanged. Reading address 0 returns the pending bits in bits [N_CH-1:0], with zeros above.
- R4: The enable register (address 1) is read/write and resets to 0. The interrupt output is high exactly when at least one channel is both pending and enabled.
- R5: Among pending, enabled channels, the lowest channel index is selected.
- R6: Reading the vector register (address 2) returns the vector RAM entry of the selected channel, or DEFAULT_VEC when no channel is pending and enabled.
- R7: The vector RAM holds N_CH entries of 32 bits. Entry i sits at address VBASE+i. A single bus write cycle stores the entry, and a read at the same address returns it.
- R8: In hardware-vectored mode (hw_mode=1), a vec_req sampled high in idle captures the selected channel and its vector onto vec_port. vec_ack rises one clock later for exactly one cycle. vec_port stays stable from the capture until the handshake returns to idle. The handshake returns to idle once vec_req has been seen low after the acknowledge.
- R9: At the clock edge where vec_ack rises, the pending bit of the captured channel is cleared and all other pending bits are left unchanged.
- R10: In software mode (hw_mode=0), vec_req is ignored: vec_ack stays low and the pending bits do not change.
- R11: If a rising edge on line i and a clear of bit i arrive in the same cycle, the bit ends up set.
- R12: After reset the pending and enable registers are 0, irq and vec_ack are low, and vec_port equals DEFAULT_VEC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N_CH | Peripheral interrupt request lines |
| bus_we | input | 1 | Register bus write strobe |
| bus_addr | input | ADDR_W | Register bus word address |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational) |
| hw_mode | input | 1 | 1 = hardware-vectored delivery, 0 = software delivery |
| irq | output | 1 | Interrupt request to the CPU |
| vec_req | input | 1 | CPU request for a vector (hardware mode) |
| vec_ack | output | 1 | Acknowledge pulse; vec_port is valid |
| vec_port | output | 32 | Handler address delivered in hardware mode |

## Verification
The hardest case to reach is a clear and a new rising edge landing on the same channel in the same cycle. The bench reaches it by changing the request line and issuing the clear write at the same falling edge. A related case is a line that stays high across a clear; the bench holds it high and checks that the flag does not come back. The hardware-vectored drain loads several pending channels at once and completes one handshake after another. Each handshake must deliver the next lowest channel's vector and retire only that channel.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_CH = 8,
  parameter int ADDR_W = 8,
  parameter int VBASE = 64,
  parameter logic [31:0] DEFAULT_VEC = 32'hDEAD_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   irq_lines,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_mode,
  output logic              irq,
  input  logic              vec_req,
  output logic              vec_ack,
  output logic [31:0]       vec_port
);
  localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(2);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_DONE} hs_t;

  logic [N_CH-1:0] req_q, pend, mask, rise, act, sw_clr, ack_clr;
  logic [31:0]     vram [N_CH];
  logic [CW-1:0]   sel, hold_ch;
  logic            any, hold_valid;
  logic [31:0]     cur_vec;
  hs_t             hs;

  assign rise = irq_lines & ~req_q;
  assign act  = pend & mask;
  assign any  = |act;
  assign irq  = any;

  always_comb begin
    sel = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (act[i]) sel = CW'(i);
  end

  assign cur_vec = any ? vram[sel] : DEFAULT_VEC;

  wire in_vram = (bus_addr >= ADDR_W'(VBASE)) && (bus_addr < ADDR_W'(VBASE + N_CH));
  wire [CW-1:0] vidx = bus_addr[CW-1:0];

  assign sw_clr  = (bus_we && bus_addr == A_PEND) ? bus_wdata[N_CH-1:0] : '0;
  assign ack_clr = (hs == S_HOLD && hold_valid) ? (N_CH'(1) << hold_ch) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
      mask  <= '0;
    end else begin
      req_q <= irq_lines;
      pend  <= (pend & ~(sw_clr | ack_clr)) | rise;
      if (bus_we && bus_addr == A_MASK) mask <= bus_wdata[N_CH-1:0];
    end
  end

  always_ff @(posedge clk)
    if (bus_we && in_vram) vram[vidx] <= bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs         <= S_IDLE;
      vec_ack    <= 1'b0;
      vec_port   <= DEFAULT_VEC;
      hold_ch    <= '0;
      hold_valid <= 1'b0;
    end else begin
      case (hs)
        S_IDLE: if (hw_mode && vec_req) begin
          hs         <= S_HOLD;
          hold_ch    <= sel;
          hold_valid <= any;
          vec_port   <= cur_vec;
        end
        S_HOLD: begin
          hs      <= S_DONE;
          vec_ack <= 1'b1;
        end
        default: begin
          vec_ack <= 1'b0;
          if (!vec_req) hs <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_PEND)      bus_rdata = 32'(pend);
    else if (bus_addr == A_MASK) bus_rdata = 32'(mask);
    else if (bus_addr == A_VEC)  bus_rdata = cur_vec;
    else if (in_vram)            bus_rdata = vram[vidx];
  end

  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise)));

  assert_set_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(rise)) == '0));

  assert_ack_follows_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs == S_HOLD) |=> vec_ack);

  assert_port_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs != S_IDLE) |=> $stable(vec_port));

  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> !vec_ack);

  assert_sw_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_mode && hs == S_IDLE) |=> !vec_ack);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int N = 8;
  localparam logic [31:0] DEF = 32'hDEAD_0000;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] lines = '0;
  logic we = 0, hw_mode = 0, vec_req = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, vec_port;
  logic irq, vec_ack;
  int total = 0, fails = 0;
  logic done = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.N_CH(N), .ADDR_W(8), .VBASE(64), .DEFAULT_VEC(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .hw_mode(hw_mode), .irq(irq),
    .vec_req(vec_req), .vec_ack(vec_ack), .vec_port(vec_port));

  function automatic logic [31:0] vv(int ch);
    return 32'h1000_0000 + 32'(ch) * 32'h40 + 32'h5;
  endfunction

  function automatic logic [31:0] exp_vec(logic [N-1:0] a);
    for (int i = 0; i < N; i++) if (a[i]) return vv(i);
    return DEF;
  endfunction

  function automatic int low_idx(logic [N-1:0] a);
    for (int i = 0; i < N; i++) if (a[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(logic [N-1:0] p);
    @(negedge clk); lines = p;
    @(negedge clk); lines = '0;
  endtask

  task automatic handshake(logic [31:0] ev, logic [N-1:0] pend_after);
    logic [31:0] d;
    vec_req = 1;
    @(negedge clk);
    chk("R8 ack low at capture", 32'(vec_ack), 0);
    chk("R8 port at capture", vec_port, ev);
    @(negedge clk);
    chk("R8 ack pulse", 32'(vec_ack), 1);
    chk("R8 port held", vec_port, ev);
    rd(8'd0, d);
    chk("R9 pending after ack", d, 32'(pend_after));
    vec_req = 0;
    @(negedge clk);
    chk("R8 ack one cycle", 32'(vec_ack), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'd0, d); chk("R12 pending reset", d, 0);
    rd(8'd1, d); chk("R12 mask reset", d, 0);
    chk("R12 irq reset", 32'(irq), 0);
    chk("R12 ack reset", 32'(vec_ack), 0);
    chk("R12 port reset", vec_port, DEF);
    rd(8'd2, d); chk("R6 default vector", d, DEF);

    for (int i = 0; i < N; i++) wr(8'(64 + i), vv(i));
    for (int i = 0; i < N; i++) begin rd(8'(64 + i), d); chk("R7 vram readback", d, vv(i)); end

    wr(8'd1, 32'hFF); rd(8'd1, d); chk("R4 mask readback", d, 32'hFF);

    pulse(8'hFF);
    rd(8'd0, d); chk("R1 edges set", d, 32'hFF);
    wr(8'd0, 32'h0F); rd(8'd0, d); chk("R3 partial clear", d, 32'hF0);
    wr(8'd0, 32'h00); rd(8'd0, d); chk("R3 zero write", d, 32'hF0);
    wr(8'd0, 32'hFF); rd(8'd0, d); chk("R3 full clear", d, 0);

    @(negedge clk); lines = 8'h04;
    @(negedge clk); rd(8'd0, d); chk("R1 held line sets", d, 32'h04);
    wr(8'd0, 32'h04);
    repeat (3) @(negedge clk);
    rd(8'd0, d); chk("R1 held line no reset", d, 0);
    lines = 8'h00; @(negedge clk); lines = 8'h04; @(negedge clk);
    rd(8'd0, d); chk("R1 new edge", d, 32'h04);
    lines = 8'h00;
    wr(8'd0, 32'hFF);

    @(negedge clk); lines = 8'h01;
    @(negedge clk); lines = 8'h00;
    @(negedge clk); lines = 8'h01; we = 1; addr = 8'd0; wdata = 32'h01;
    @(negedge clk); we = 0; lines = 8'h00;
    rd(8'd0, d); chk("R11 set beats clear", d, 32'h01);

    pulse(8'h01); pulse(8'h01);
    wr(8'd0, 32'h01);
    rd(8'd0, d); chk("R2 merged edges", d, 0);
    chk("R2 irq after single clear", 32'(irq), 0);

    for (int v = 0; v < 256; v++) begin
      p = N'(v);
      wr(8'd0, 32'hFF);
      pulse(p);
      rd(8'd0, d); chk("R1 pattern", d, 32'(p));
      chk("R4 irq pattern", 32'(irq), 32'(p != 0));
      rd(8'd2, d); chk("R5 R6 vector pattern", d, exp_vec(p));
    end

    wr(8'd0, 32'hFF); pulse(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wr(8'd1, 32'(m));
      chk("R4 irq mask", 32'(irq), 32'(m != 0));
      rd(8'd2, d); chk("R5 R6 vector mask", d, exp_vec(N'(m)));
    end

    wr(8'd1, 32'hFF);
    hw_mode = 0;
    @(negedge clk); vec_req = 1;
    repeat (4) begin @(negedge clk); chk("R10 no ack in sw mode", 32'(vec_ack), 0); end
    vec_req = 0;
    rd(8'd0, d); chk("R10 pending untouched", d, 32'hFF);

    hw_mode = 1;
    foreach (p[i]) ;
    for (int t = 0; t < 3; t++) begin
      logic [N-1:0] cur;
      cur = (t == 0) ? 8'hA5 : (t == 1) ? 8'h80 : 8'hFF;
      wr(8'd0, 32'hFF); pulse(cur);
      while (cur != 0) begin
        logic [N-1:0] nxt;
        nxt = cur & ~(N'(1) << low_idx(cur));
        @(negedge clk);
        handshake(exp_vec(cur), nxt);
        cur = nxt;
      end
      chk("R9 drained irq", 32'(irq), 0);
    end
    @(negedge clk);
    handshake(DEF, '0);

    wr(8'd1, 32'h0F); pulse(8'hF8);
    @(negedge clk);
    handshake(vv(3), 8'hF0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule